// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two 8-bit buses, A and B, with a non-inverting transceiver. Each direction has its own capture register. A direction can forward the live value from the opposite bus, or it can replay the value captured earlier from that bus. Each bus side has an output enable, and the two enables have opposite polarity. With both enables off, both buses are inputs only. Capture does not depend on the enables. The block can therefore store a value it is driving itself into the register of the other direction, which copies one bus value into both registers.

Every port has its own input, output and enable, so no tri-state is needed on chip. Whatever fabric resolves the bus combines the `*_o` and `*_oe_o` pair of each side with the external drivers. Capture is qualified by two strobes sampled on one system clock, so each register behaves as an independently clocked edge-triggered store. If both buses are driven and either direction asks for live data, the path would close into a combinational loop. The block breaks that loop by forcing stored data in both directions and raises a conflict flag.

Top module: `xcvr_reg_bridge`

## Requirements
- R1: An active-low asynchronous reset clears both capture registers to zero. Both output enables follow their enable inputs directly, so with both enables inactive, both buses stay undriven.
- R2: On a clock edge with `cap_ab_i` high, the A-side register loads the value present on bus A. With `cap_ab_i` low, it keeps its value.
- R3: On a clock edge with `cap_ba_i` high, the B-side register loads the value present on bus B. With `cap_ba_i` low, it keeps its value. Capture on either side works whatever the enables are.
- R4: `b_oe_o` equals `drv_b_i`, which is active high. `a_oe_o` equals the inverse of `drv_a_ni`, which is active low. A disabled side outputs all zeros on its data port.
- R5: While bus B is driven and bus A is not, `sel_ab_i` = 0 puts live `a_i` on `b_o`, and `sel_ab_i` = 1 puts the A-side register on `b_o`.
- R6: While bus A is driven and bus B is not, `sel_ba_i` = 0 puts live `b_i` on `a_o`, and `sel_ba_i` = 1 puts the B-side register on `a_o`.
- R7: When the block drives B with live A data and `cap_ba_i` is high, the B-side register stores the driven value, which is the A bus value.
- R8: When the block drives A with live B data and `cap_ab_i` is high, the A-side register stores the driven value, which is the B bus value.
- R9: When both buses are driven and both selects are 1, `a_o` carries the B-side register, `b_o` carries the A-side register, and `conflict_o` is 0.
- R10: When both buses are driven and either select is 0, both outputs carry stored data as in R9 and `conflict_o` is 1. Otherwise `conflict_o` is 0. A capture in this state swaps the register contents.
- R11: Every path is bit-for-bit non-inverting over the full `W`-bit width (default 8).
- R12: In the store-A-into-both mode of R7, `cap_ab_i` and `cap_ba_i` may both be high on the same edge, and both registers then load the A bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; captures occur on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_ab_i | input | 1 | Capture strobe for the A-side register |
| cap_ba_i | input | 1 | Capture strobe for the B-side register |
| sel_ab_i | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source for bus A: 0 live B, 1 stored B |
| drv_b_i | input | 1 | Drive enable for bus B, active high |
| drv_a_ni | input | 1 | Drive enable for bus A, active low |
| a_i | input | W | Value seen on bus A from outside |
| a_o | output | W | Value the block drives on bus A |
| a_oe_o | output | 1 | Block drives bus A |
| b_i | input | W | Value seen on bus B from outside |
| b_o | output | W | Value the block drives on bus B |
| b_oe_o | output | 1 | Block drives bus B |
| conflict_o | output | 1 | Both buses driven while a live path was requested |

## Verification
The embedded properties watch the register behaviour on every cycle: load on a strobe and hold without one. They also check that both outputs carry stored data whenever both sides drive, that the conflict flag only appears with both sides driving, and that a self-driven B bus lands in the B-side register. Only the bench scenarios show the following: the operating-mode rows taken one at a time with concrete data, the register swap under conflict, simultaneous capture, and the absence of bus contention with an external driver.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

  // decoded control for both directions
  typedef struct packed {
    logic a_en;     // block drives bus A
    logic b_en;     // block drives bus B
    logic q_to_b;   // bus B fed from A-side register
    logic q_to_a;   // bus A fed from B-side register
    logic conflict; // live path requested with both buses driven
  } xcvr_ctl_t;

endpackage

// File: rtl/xcvr_ctrl.sv
`timescale 1ns/1ps
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic      sel_ab_i,
  input  logic      sel_ba_i,
  input  logic      drv_b_i,
  input  logic      drv_a_ni,
  output xcvr_ctl_t ctl_o
);

  logic both_drv;

  always_comb begin
    both_drv       = drv_b_i & ~drv_a_ni;
    ctl_o.a_en     = ~drv_a_ni;
    ctl_o.b_en     = drv_b_i;
    // both sides driven: live paths would loop, force stored data
    ctl_o.q_to_b   = sel_ab_i | both_drv;
    ctl_o.q_to_a   = sel_ba_i | both_drv;
    ctl_o.conflict = both_drv & ~(sel_ab_i & sel_ba_i);
  end

endmodule

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] pin_i,   // resolved source bus value
  input  logic [W-1:0] live_i,  // external source value, used only when source is undriven
  input  logic         use_q_i,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] out_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (cap_i) q_q <= pin_i;
  end

  assign q_o   = q_q;
  assign out_o = !en_i ? '0 : (use_q_i ? q_q : live_i);

  // R2
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (q_o == $past(pin_i)));

  // R3
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));

endmodule

// File: rtl/xcvr_reg_bridge.sv
`timescale 1ns/1ps
module xcvr_reg_bridge
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         drv_b_i,
  input  logic         drv_a_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  output logic         conflict_o
);

  xcvr_ctl_t    ctl;
  logic [W-1:0] a_pin, b_pin;
  logic [W-1:0] q_a, q_b;
  logic [W-1:0] to_b, to_a;

  xcvr_ctrl i_ctrl (
    .sel_ab_i (sel_ab_i),
    .sel_ba_i (sel_ba_i),
    .drv_b_i  (drv_b_i),
    .drv_a_ni (drv_a_ni),
    .ctl_o    (ctl)
  );

  // capture sees the pin, including our own drive
  assign a_pin = ctl.a_en ? to_a : a_i;
  assign b_pin = ctl.b_en ? to_b : b_i;

  xcvr_path #(.W(W)) i_path_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_ab_i),
    .pin_i   (a_pin),
    .live_i  (a_i),
    .use_q_i (ctl.q_to_b),
    .en_i    (ctl.b_en),
    .q_o     (q_a),
    .out_o   (to_b)
  );

  xcvr_path #(.W(W)) i_path_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_ba_i),
    .pin_i   (b_pin),
    .live_i  (b_i),
    .use_q_i (ctl.q_to_a),
    .en_i    (ctl.a_en),
    .q_o     (q_b),
    .out_o   (to_a)
  );

  assign a_o        = to_a;
  assign b_o        = to_b;
  assign a_oe_o     = ctl.a_en;
  assign b_oe_o     = ctl.b_en;
  assign conflict_o = ctl.conflict;

  // R9
  both_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && b_oe_o) |-> (a_o == q_b && b_o == q_a));

  // R10
  conflict_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (a_oe_o && b_oe_o));

  // R7
  loop_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !a_oe_o && !sel_ab_i && cap_ba_i) |=> (q_b == $past(a_i)));

endmodule

// File: tb/test_xcvr_reg_bridge.sv
`timescale 1ns/1ps
module test_xcvr_reg_bridge;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cap_ab, cap_ba, sel_ab, sel_ba, drv_b, drv_a_n;
  logic [W-1:0] ext_a, ext_b;
  logic         ext_a_en, ext_b_en;
  logic [W-1:0] a_in, b_in, a_o, b_o;
  logic         a_oe, b_oe, conflict;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    string        req;
    logic         a_oe;
    logic [W-1:0] a;
    logic         b_oe;
    logic [W-1:0] b;
    logic         conf;
  } exp_t;

  exp_t exp_q[$];
  logic [W-1:0] m_ra, m_rb;

  always #2.5 clk = ~clk;

  assign a_in = ext_a_en ? ext_a : '0;
  assign b_in = ext_b_en ? ext_b : '0;

  xcvr_reg_bridge #(.W(W)) i_xcvr_reg_bridge (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cap_ab_i   (cap_ab),
    .cap_ba_i   (cap_ba),
    .sel_ab_i   (sel_ab),
    .sel_ba_i   (sel_ba),
    .drv_b_i    (drv_b),
    .drv_a_ni   (drv_a_n),
    .a_i        (a_in),
    .a_o        (a_o),
    .a_oe_o     (a_oe),
    .b_i        (b_in),
    .b_o        (b_o),
    .b_oe_o     (b_oe),
    .conflict_o (conflict)
  );

  // driver: apply one cycle of stimulus, push expectation, advance model
  task automatic step(input string req, input logic cab, input logic cba,
                      input logic sab, input logic sba, input logic db,
                      input logic dan, input logic [W-1:0] ea,
                      input logic [W-1:0] eb);
    exp_t e;
    logic both;
    logic [W-1:0] pa, pb;
    @(negedge clk);
    cap_ab = cab; cap_ba = cba; sel_ab = sab; sel_ba = sba;
    drv_b = db; drv_a_n = dan;
    ext_a = ea; ext_b = eb;
    ext_a_en = dan;   // outside drives A only while the block does not
    ext_b_en = !db;
    both   = db && !dan;
    e.req  = req;
    e.b_oe = db;
    e.a_oe = !dan;
    e.b    = !db ? '0 : ((sab || both) ? m_ra : ea);
    e.a    = dan ? '0 : ((sba || both) ? m_rb : eb);
    e.conf = both && !(sab && sba);
    exp_q.push_back(e);
    pa = !dan ? e.a : ea;
    pb = db ? e.b : eb;
    if (cab) m_ra = pa;
    if (cba) m_rb = pb;
  endtask

  // monitor: compare outputs mid-cycle, after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (a_oe !== e.a_oe || a_o !== e.a || b_oe !== e.b_oe ||
            b_o !== e.b || conflict !== e.conf) begin
          n_fail++;
          $display("FAIL %s: got a_oe=%b a=%h b_oe=%b b=%h conf=%b exp a_oe=%b a=%h b_oe=%b b=%h conf=%b",
                   e.req, a_oe, a_o, b_oe, b_o, conflict,
                   e.a_oe, e.a, e.b_oe, e.b, e.conf);
        end
      end
      if (rst_n) begin
        n_checks++;
        if ((ext_a_en && a_oe) || (ext_b_en && b_oe)) begin
          n_fail++;
          $display("FAIL R4: bus contention got a_oe=%b b_oe=%b exp no overlap with external drivers",
                   a_oe, b_oe);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cap_ab = 0; cap_ba = 0; sel_ab = 0; sel_ba = 0;
    drv_b = 0; drv_a_n = 1;
    ext_a = '0; ext_b = '0; ext_a_en = 1; ext_b_en = 1;
    m_ra = '0; m_rb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset cleared, observed via stored paths with both sides driven
    step("R1", 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);
    // R4 isolation with R2/R3 capture from external drivers
    step("R4", 1, 1, 0, 0, 0, 1, 8'h3C, 8'hA5);
    // R2 hold without strobe
    step("R2", 0, 0, 0, 0, 0, 1, 8'hFF, 8'hFF);
    step("R5", 0, 0, 1, 0, 1, 1, 8'h11, 8'h00);
    step("R5", 0, 0, 0, 0, 1, 1, 8'h96, 8'h00);
    step("R6", 0, 0, 0, 1, 0, 0, 8'h00, 8'h22);
    step("R3", 0, 0, 0, 1, 0, 0, 8'h00, 8'h22);
    step("R6", 0, 0, 0, 0, 0, 0, 8'h00, 8'h69);
    // R7: drive B live from A, capture B register
    step("R7", 0, 1, 0, 0, 1, 1, 8'h5A, 8'h00);
    step("R7", 0, 0, 0, 1, 0, 0, 8'h00, 8'h00);
    // R12: both strobes on one edge
    step("R12", 1, 1, 0, 0, 1, 1, 8'hC3, 8'h00);
    step("R12", 0, 0, 1, 0, 1, 1, 8'h00, 8'h00);
    step("R12", 0, 0, 0, 1, 0, 0, 8'h00, 8'h00);
    // R8: drive A live from B, capture A register
    step("R8", 1, 0, 0, 0, 0, 0, 8'h00, 8'h77);
    step("R8", 0, 0, 1, 0, 1, 1, 8'h00, 8'h00);
    step("R9", 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);
    // R10: conflict forces stored data; capture swaps registers
    step("R10", 1, 1, 0, 1, 1, 0, 8'hEE, 8'hDD);
    step("R10", 0, 0, 1, 0, 1, 0, 8'h00, 8'h00);
    step("R10", 0, 0, 0, 0, 1, 0, 8'h00, 8'h00);
    step("R9", 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);
    // R11: single-bit and alternating patterns pass unchanged
    step("R11", 0, 0, 0, 0, 1, 1, 8'h01, 8'h00);
    step("R11", 0, 0, 0, 0, 1, 1, 8'h80, 8'h00);
    step("R11", 0, 0, 0, 0, 0, 0, 8'h00, 8'h55);
    step("R11", 0, 0, 0, 0, 0, 0, 8'h00, 8'hAA);
    step("R4", 0, 0, 1, 1, 0, 1, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, exp finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule